// File: doc/BRIEF.md
# Split Status Flag Register

This block holds the condition and status flags of a processor core as three separately written groups rather than one monolithic register. The arithmetic group carries negative, zero, carry and overflow; the saturation group carries one sticky overflow-saturation bit; the lane-compare group carries four per-byte greater-or-equal bits. Each group has its own write port. An instruction that touches only one group therefore never has to read the other two in order to write them back unchanged.

Around the three groups the block builds a composite 32-bit status word. A masked form of it serves status reads, and an unmasked form serves exception saves. The block also splits a full status-word write back into the groups, passing the non-flag bits on to the separate control register. A condition evaluator decides whether a 4-bit condition code passes, looking at the arithmetic group only. Mode, interrupt-mask and execution-state bits come in from outside on a control input.

Top module: `status_flag_split`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all three flag groups to zero, and it takes priority over every write port.
- R2: An arithmetic update (`alu_we`) replaces bits 31:28 of the status word with `alu_nzcv` (bit 3 is N at 31, then Z at 30, C at 29, V at 28) at the next clock edge. The saturation and lane-compare groups are left unchanged.
- R3: A multiply update (`mul_we`) replaces only N and Z (bits 31:30) with `mul_nz` and keeps the existing C and V bits.
- R4: A saturation update (`sat_we`) ORs `sat_bit` into bit 27. No group write ever clears bit 27, so writing 0 through this port has no effect.
- R5: A lane-compare update (`ge_we`) replaces all four bits 19:16 with `ge_val`, with no merge with the old value.
- R6: `save_word` equals `ctrl_in` ORed with the flag groups at their positions. `status_rd` equals that same word ANDed with 0xF8FF03DF. Both are combinational on the current state.
- R7: A full-word write (`full_we`) loads each group from `full_word` under its mask: 0xF0000000, 0x08000000 and 0x000F0000. In the same cycle, `ctrl_wr_en` is high and `ctrl_wr_data` equals `full_word` ANDed with the inverse of 0xF80F0000. A full-word write is the only way to clear bit 27.
- R8: When a full-word write coincides with any group write, the full-word write alone determines all three groups.
- R9: When arithmetic and multiply updates coincide without a full-word write, the arithmetic update determines all four of N, Z, C and V.
- R10: `cond_pass` evaluates `cond_code` on the current N, Z, C and V bits. The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !(C&!Z); 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 !(!Z&(N==V)).
- R11: Codes 14 (always) and 15 (unconditional) evaluate on zero flags in place of the stored ones, and always pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_in | input | 32 | Control bits from the separate control register |
| full_we | input | 1 | Full status-word write strobe |
| full_word | input | 32 | Full status word to be split |
| alu_we | input | 1 | Arithmetic group update strobe |
| alu_nzcv | input | 4 | New N, Z, C, V (bit 3 = N) |
| mul_we | input | 1 | Multiply update strobe (N and Z only) |
| mul_nz | input | 2 | New N, Z (bit 1 = N) |
| sat_we | input | 1 | Saturation update strobe |
| sat_bit | input | 1 | Value ORed into the sticky bit |
| ge_we | input | 1 | Lane-compare update strobe |
| ge_val | input | 4 | New lane-compare bits |
| cond_code | input | 4 | Condition code to evaluate |
| status_rd | output | 32 | Masked composite status word for reads |
| save_word | output | 32 | Unmasked composite word for exception save |
| ctrl_wr_en | output | 1 | Control register write strobe |
| ctrl_wr_data | output | 32 | Non-flag bits of the full write |
| cond_pass | output | 1 | Condition result |

## Verification
The hardest situations to reach are the write collisions: a full-word write in the same cycle as arithmetic, multiply, saturation and lane-compare updates, and an arithmetic update in the same cycle as a multiply update. Close behind is the single legal path that clears the sticky bit. Random stimulus raises every group strobe often and the full-word strobe rarely, so the sticky bit stays set for long stretches and collisions occur in many combinations. Directed steps force all strobes together and clear the sticky bit through a full-word write of zero. A sweep of full-word writes then sets every combination of the four arithmetic flags and evaluates every condition code against each.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int WORD_W  = 32;
  localparam int NZCV_W  = 4;
  localparam int NZCV_LO = 28;
  localparam int Q_POS   = 27;
  localparam int GE_W    = 4;
  localparam int GE_LO   = 16;
  localparam int CC_W    = 4;

  localparam logic [WORD_W-1:0] ARITH_MASK = 32'hF000_0000;
  localparam logic [WORD_W-1:0] SAT_MASK   = 32'h0800_0000;
  localparam logic [WORD_W-1:0] GE_MASK    = 32'h000F_0000;
  localparam logic [WORD_W-1:0] FLAG_MASK  = ARITH_MASK | SAT_MASK | GE_MASK;
  localparam logic [WORD_W-1:0] READ_MASK  = 32'hF8FF_03DF;

  typedef enum logic [CC_W-1:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_UN = 4'hF
  } cond_e;

  // place the three groups at their positions in a 32-bit word
  function automatic logic [WORD_W-1:0] pack_flags(
    input logic [NZCV_W-1:0] nzcv,
    input logic              q,
    input logic [GE_W-1:0]   ge
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[NZCV_LO +: NZCV_W] = nzcv;
    w[Q_POS]             = q;
    w[GE_LO +: GE_W]     = ge;
    return w;
  endfunction

  // true when the condition code is one that ignores the flags
  function automatic logic cc_ignores_flags(input logic [CC_W-1:0] cc);
    return (cc == CC_AL) || (cc == CC_UN);
  endfunction

  // condition predicate on N,Z,C,V (bit 3 = N)
  function automatic logic cond_holds(
    input logic [CC_W-1:0]   cc,
    input logic [NZCV_W-1:0] f
  );
    logic n, z, c, v, r;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (cond_e'(cc))
      CC_EQ: r = z;
      CC_NE: r = !z;
      CC_CS: r = c;
      CC_CC: r = !c;
      CC_MI: r = n;
      CC_PL: r = !n;
      CC_VS: r = v;
      CC_VC: r = !v;
      CC_HI: r = c && !z;
      CC_LS: r = !c || z;
      CC_GE: r = (n == v);
      CC_LT: r = (n != v);
      CC_GT: r = !z && (n == v);
      CC_LE: r = z || (n != v);
      default: r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sflag_arith_grp.sv
module sflag_arith_grp
  import sflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              full_we,
  input  logic [NZCV_W-1:0] full_nzcv,
  input  logic              alu_we,
  input  logic [NZCV_W-1:0] alu_nzcv,
  input  logic              mul_we,
  input  logic [1:0]        mul_nz,
  output logic [NZCV_W-1:0] nzcv_q
);
  logic              take_full, take_alu, take_mul;
  logic [NZCV_W-1:0] nzcv_d;

  assign take_full = full_we;
  assign take_alu  = alu_we && !full_we;
  assign take_mul  = mul_we && !alu_we && !full_we;

  always_comb begin
    nzcv_d = nzcv_q;
    if (take_full)     nzcv_d = full_nzcv;
    else if (take_alu) nzcv_d = alu_nzcv;
    else if (take_mul) nzcv_d = {mul_nz, nzcv_q[1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) nzcv_q <= '0;
    else     nzcv_q <= nzcv_d;
  end

  assert_arith_reset_R1: assert property (@(posedge clk)
    rst |=> nzcv_q == '0);

  assert_alu_all_four_R2: assert property (@(posedge clk) disable iff (rst)
    (alu_we && !full_we) |=> nzcv_q == $past(alu_nzcv));

  assert_mul_keeps_cv_R3: assert property (@(posedge clk) disable iff (rst)
    (mul_we && !alu_we && !full_we) |=>
      (nzcv_q[1:0] == $past(nzcv_q[1:0])) && (nzcv_q[3:2] == $past(mul_nz)));

  assert_full_wins_arith_R8: assert property (@(posedge clk) disable iff (rst)
    full_we |=> nzcv_q == $past(full_nzcv));

  assert_alu_over_mul_R9: assert property (@(posedge clk) disable iff (rst)
    (alu_we && mul_we && !full_we) |=> nzcv_q[1:0] == $past(alu_nzcv[1:0]));
endmodule

// File: rtl/sflag_sat_grp.sv
module sflag_sat_grp
  import sflag_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic full_we,
  input  logic full_q,
  input  logic sat_we,
  input  logic sat_bit,
  output logic q_q
);
  logic sat_set, q_d;

  assign sat_set = sat_we && sat_bit && !full_we;

  always_comb begin
    q_d = q_q;
    if (full_we)      q_d = full_q;
    else if (sat_set) q_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q_q <= 1'b0;
    else     q_q <= q_d;
  end

  assert_sat_reset_R1: assert property (@(posedge clk)
    rst |=> !q_q);

  assert_sat_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (q_q && !full_we) |=> q_q);

  assert_sat_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (sat_we && sat_bit && !full_we) |=> q_q);

  assert_full_loads_q_R7: assert property (@(posedge clk) disable iff (rst)
    full_we |=> q_q == $past(full_q));
endmodule

// File: rtl/sflag_ge_grp.sv
module sflag_ge_grp
  import sflag_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            full_we,
  input  logic [GE_W-1:0] full_ge,
  input  logic            ge_we,
  input  logic [GE_W-1:0] ge_val,
  output logic [GE_W-1:0] ge_q
);
  logic            take_lane;
  logic [GE_W-1:0] ge_d;

  assign take_lane = ge_we && !full_we;

  always_comb begin
    ge_d = ge_q;
    if (full_we)        ge_d = full_ge;
    else if (take_lane) ge_d = ge_val;
  end

  always_ff @(posedge clk) begin
    if (rst) ge_q <= '0;
    else     ge_q <= ge_d;
  end

  assert_ge_reset_R1: assert property (@(posedge clk)
    rst |=> ge_q == '0);

  assert_ge_replace_R5: assert property (@(posedge clk) disable iff (rst)
    (ge_we && !full_we) |=> ge_q == $past(ge_val));

  assert_ge_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ge_we && !full_we) |=> $stable(ge_q));

  assert_full_wins_ge_R8: assert property (@(posedge clk) disable iff (rst)
    full_we |=> ge_q == $past(full_ge));
endmodule

// File: rtl/sflag_cond_eval.sv
module sflag_cond_eval
  import sflag_pkg::*;
(
  input  logic [CC_W-1:0]   cond_code,
  input  logic [NZCV_W-1:0] nzcv,
  output logic              flags_read,
  output logic              cond_pass
);
  logic [NZCV_W-1:0] nzcv_eff;

  // the always and unconditional codes read zero, not the flag group
  assign flags_read = !cc_ignores_flags(cond_code);
  assign nzcv_eff   = flags_read ? nzcv : '0;
  assign cond_pass  = cond_holds(cond_code, nzcv_eff);
endmodule

// File: rtl/status_flag_split.sv
module status_flag_split
  import sflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] ctrl_in,
  input  logic              full_we,
  input  logic [WORD_W-1:0] full_word,
  input  logic              alu_we,
  input  logic [NZCV_W-1:0] alu_nzcv,
  input  logic              mul_we,
  input  logic [1:0]        mul_nz,
  input  logic              sat_we,
  input  logic              sat_bit,
  input  logic              ge_we,
  input  logic [GE_W-1:0]   ge_val,
  input  logic [CC_W-1:0]   cond_code,
  output logic [WORD_W-1:0] status_rd,
  output logic [WORD_W-1:0] save_word,
  output logic              ctrl_wr_en,
  output logic [WORD_W-1:0] ctrl_wr_data,
  output logic              cond_pass
);
  logic [NZCV_W-1:0] nzcv_q;
  logic              q_q;
  logic [GE_W-1:0]   ge_q;
  logic [WORD_W-1:0] flag_word;
  logic              flags_read;

  sflag_arith_grp u_arith (
    .clk       (clk),
    .rst       (rst),
    .full_we   (full_we),
    .full_nzcv (full_word[NZCV_LO +: NZCV_W]),
    .alu_we    (alu_we),
    .alu_nzcv  (alu_nzcv),
    .mul_we    (mul_we),
    .mul_nz    (mul_nz),
    .nzcv_q    (nzcv_q)
  );

  sflag_sat_grp u_sat (
    .clk     (clk),
    .rst     (rst),
    .full_we (full_we),
    .full_q  (full_word[Q_POS]),
    .sat_we  (sat_we),
    .sat_bit (sat_bit),
    .q_q     (q_q)
  );

  sflag_ge_grp u_ge (
    .clk     (clk),
    .rst     (rst),
    .full_we (full_we),
    .full_ge (full_word[GE_LO +: GE_W]),
    .ge_we   (ge_we),
    .ge_val  (ge_val),
    .ge_q    (ge_q)
  );

  sflag_cond_eval u_cond (
    .cond_code  (cond_code),
    .nzcv       (nzcv_q),
    .flags_read (flags_read),
    .cond_pass  (cond_pass)
  );

  assign flag_word    = pack_flags(nzcv_q, q_q, ge_q);
  assign save_word    = ctrl_in | flag_word;
  assign status_rd    = save_word & READ_MASK;
  assign ctrl_wr_en   = full_we;
  assign ctrl_wr_data = full_word & ~(ARITH_MASK | SAT_MASK | GE_MASK);

  assert_ctrl_no_flags_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr_en |-> (ctrl_wr_data & FLAG_MASK) == '0);

  assert_always_passes_R11: assert property (@(posedge clk) disable iff (rst)
    !flags_read |-> cond_pass);

  assert_read_tracks_arith_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_in[31:28] == '0) |-> status_rd[31:28] == nzcv_q);
endmodule

// File: tb/status_flag_split_tb.sv
module status_flag_split_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] ctrl_in, full_word;
  logic        full_we, alu_we, mul_we, sat_we, sat_bit, ge_we;
  logic [3:0]  alu_nzcv, ge_val, cond_code;
  logic [1:0]  mul_nz;
  logic [31:0] status_rd, save_word, ctrl_wr_data;
  logic        ctrl_wr_en, cond_pass;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench model of the flag state
  bit [3:0] m_f;
  bit       m_q;
  bit [3:0] m_ge;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_split u_dut (
    .clk(clk), .rst(rst), .ctrl_in(ctrl_in),
    .full_we(full_we), .full_word(full_word),
    .alu_we(alu_we), .alu_nzcv(alu_nzcv),
    .mul_we(mul_we), .mul_nz(mul_nz),
    .sat_we(sat_we), .sat_bit(sat_bit),
    .ge_we(ge_we), .ge_val(ge_val),
    .cond_code(cond_code),
    .status_rd(status_rd), .save_word(save_word),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
    .cond_pass(cond_pass)
  );

  function automatic bit exp_cond(bit [3:0] cc, bit [3:0] f);
    bit n, z, c, v, b;
    if (cc[3:1] == 3'b111) return 1'b1;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (cc[3:1])
      3'd0: b = z;
      3'd1: b = c;
      3'd2: b = n;
      3'd3: b = v;
      3'd4: b = c & ~z;
      3'd5: b = ~(n ^ v);
      default: b = ~z & ~(n ^ v);
    endcase
    return cc[0] ? ~b : b;
  endfunction

  function automatic bit [31:0] exp_save();
    bit [31:0] w;
    w = {m_f, m_q, 27'd0} | {12'd0, m_ge, 16'd0};
    return ctrl_in | w;
  endfunction

  task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    full_we = 0; alu_we = 0; mul_we = 0; sat_we = 0; ge_we = 0;
  endtask

  // inputs are set after a falling edge; check, clock, update the model
  task automatic cycle(string tag);
    #1;
    check({tag, " R6 save_word"}, save_word, exp_save());
    check({tag, " R6 status_rd"}, status_rd, exp_save() & 32'hF8FF_03DF);
    check({tag, " R10 cond_pass"}, {31'd0, cond_pass}, {31'd0, exp_cond(cond_code, m_f)});
    check({tag, " R7 ctrl_wr_en"}, {31'd0, ctrl_wr_en}, {31'd0, full_we});
    if (full_we)
      check({tag, " R7 ctrl_wr_data"}, ctrl_wr_data, full_word & 32'h07F0_FFFF);
    @(posedge clk);
    if (rst) begin
      m_f = '0; m_q = 0; m_ge = '0;
    end else if (full_we) begin
      m_f = full_word[31:28]; m_q = full_word[27]; m_ge = full_word[19:16];
    end else begin
      if (alu_we)      m_f = alu_nzcv;
      else if (mul_we) m_f[3:2] = mul_nz;
      if (sat_we)      m_q = m_q | sat_bit;
      if (ge_we)       m_ge = ge_val;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'h1357_2468;
    void'($urandom(seed));
    m_f = '0; m_q = 0; m_ge = '0;
    rst = 1; ctrl_in = '0; full_word = 32'hFFFF_FFFF; cond_code = 4'h0;
    full_we = 1; alu_we = 1; alu_nzcv = 4'hF; mul_we = 0; mul_nz = '0;
    sat_we = 1; sat_bit = 1; ge_we = 1; ge_val = 4'hF;
    @(negedge clk);
    @(negedge clk);
    rst = 1;
    cycle("R1 reset over writes");
    rst = 0; idle();
    #1;
    check("R1 reset state", save_word, 32'h0);

    // R2: arithmetic update leaves Q and GE alone
    sat_we = 1; sat_bit = 1; ge_we = 1; ge_val = 4'h9;
    cycle("R4 R5 setup");
    idle(); alu_we = 1; alu_nzcv = 4'b1010;
    cycle("R2 alu write");
    idle(); #1;
    check("R2 alu keeps Q GE", save_word, 32'hA809_0000);

    // R3: multiply update keeps C and V
    alu_we = 1; alu_nzcv = 4'b0011;
    cycle("R3 setup");
    idle(); mul_we = 1; mul_nz = 2'b10;
    cycle("R3 mul write");
    idle(); #1;
    check("R3 mul keeps CV", save_word[31:28], 32'hB);

    // R4: writing zero and other group writes never clear Q
    sat_we = 1; sat_bit = 0; alu_we = 1; alu_nzcv = 4'h0; ge_we = 1; ge_val = 4'h0;
    cycle("R4 zero write");
    idle(); #1;
    check("R4 Q sticky", save_word, 32'h0800_0000);

    // R5: GE replace without merge
    ge_we = 1; ge_val = 4'hF; cycle("R5 ge set");
    idle(); ge_we = 1; ge_val = 4'h2; cycle("R5 ge replace");
    idle(); #1;
    check("R5 ge replaced", save_word[19:16], 32'h2);

    // R7: full write, then clear Q via full write of zero
    full_we = 1; full_word = 32'hFFFF_FFFF; cycle("R7 full ones");
    idle(); #1;
    check("R7 full ones groups", save_word, 32'hF80F_0000);
    full_we = 1; full_word = 32'h0; cycle("R7 full zero");
    idle(); #1;
    check("R7 Q cleared by full write", save_word, 32'h0);

    // R8: full write collides with every group write
    full_we = 1; full_word = 32'h5003_0000;
    alu_we = 1; alu_nzcv = 4'hF; mul_we = 1; mul_nz = 2'b11;
    sat_we = 1; sat_bit = 1; ge_we = 1; ge_val = 4'hC;
    cycle("R8 collision");
    idle(); #1;
    check("R8 full wins", save_word, 32'h5003_0000);

    // R9: alu beats mul
    alu_we = 1; alu_nzcv = 4'b0101; mul_we = 1; mul_nz = 2'b10;
    cycle("R9 alu vs mul");
    idle(); #1;
    check("R9 alu wins", save_word[31:28], 32'h5);

    // R6: control bits merge and read mask
    ctrl_in = 32'hFFFF_FFFF; #1;
    check("R6 read mask", status_rd, 32'hF8FF_03DF);
    check("R6 save unmasked", save_word, 32'hFFFF_FFFF);
    ctrl_in = 32'h0000_01D3; cycle("R6 ctrl merge");

    // R10 R11: every flag pattern against every code
    for (int f = 0; f < 16; f++) begin
      idle(); full_we = 1; full_word = {f[3:0], 28'h0}; cycle("R10 load flags");
      idle();
      for (int cc = 0; cc < 16; cc++) begin
        cond_code = cc[3:0];
        cycle(cc >= 14 ? "R11 always codes" : "R10 sweep");
      end
    end

    // random phase
    for (int i = 0; i < 2000; i++) begin
      ctrl_in   = $urandom;
      full_we   = ($urandom % 8) == 0;
      full_word = $urandom;
      alu_we    = ($urandom % 3) == 0;
      alu_nzcv  = 4'($urandom);
      mul_we    = ($urandom % 4) == 0;
      mul_nz    = 2'($urandom);
      sat_we    = ($urandom % 3) == 0;
      sat_bit   = 1'($urandom);
      ge_we     = ($urandom % 4) == 0;
      ge_val    = 4'($urandom);
      cond_code = 4'($urandom);
      cycle("random R2 R3 R4 R5 R8 R9");
    end

    idle();
    cycle("final");
    finish_run();
  end
endmodule